// File: doc/BRIEF.md
# Double-Edge Write Capture with Byte Masks

This block sits behind the data pins of a double-data-rate memory port. During a write burst, each of the two byte lanes has its own strobe and its own mask input. Data and mask are taken on every strobe transition, both rising and falling. A mask bit that is high blocks the write of the byte it travels with. The block gathers a burst of 2, 4 or 8 beats into one registered word array, with a byte-enable pair for each beat, and raises a one-clock done pulse once both lanes have delivered their last beat. For reads, it registers the outgoing words and drives both strobes so that each strobe transition lands in the same clock as a data change.

The strobe, data and mask pins are oversampled by the block clock `clk`. The pins are assumed to be already delay-aligned upstream, so the clock samples each data bit in its stable centre. A strobe transition is found by comparing two successive samples. Each lane detects its own transitions, so a skew between the lanes is tolerated. The write window is framed by `wr_arm`. The strobe idles low, and the first beat of a burst is the first rising strobe transition seen while armed.

Top module: `dqs_capture_unit`

## Requirements
- R1: Each lane captures one beat on every strobe transition, rising or falling, once its burst has started. Beat k of the burst is the byte present at the k-th captured transition.
- R2: The lower strobe (`dqs_in[0]`) and mask (`dm_in[0]`) govern data bits 7:0. The upper strobe and mask govern bits 15:8. The two lanes count their beats independently, so the lanes may be skewed by any number of clocks.
- R3: In `burst_we`, bit k*2+l is the enable for beat k, lane l. It equals the inverse of the mask bit sampled with that byte: 1 means write, and 0 means the byte is masked.
- R4: The burst length is taken from `bl_sel`: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 gives 8 beats. In `burst_dq`, beat k occupies bits k*16+15 down to k*16.
- R5: While `wr_arm` is low, strobe transitions are ignored. After arming, a falling transition that comes before the first rising one (the preamble) is ignored. The first rising transition is beat 0.
- R6: `burst_done` is a single-clock pulse. It rises two clocks after the clock edge that samples the last strobe transition of the later lane. In that cycle, `burst_dq` and `burst_we` hold the finished burst.
- R7: Once a lane has received all its beats, further transitions on its strobe are ignored until the burst completes.
- R8: After reset, `burst_done`, `burst_dq`, `burst_we`, `dq_out`, `dq_oe`, `dqs_out` and `dqs_oe` are all zero.
- R9: On a read, a word presented with `rd_beat_vld` appears on `dq_out` one clock later, with `dq_oe` and `dqs_oe` high. Both strobe outputs are equal. The first beat of a run drives them high, and each further beat toggles them, so every data change coincides with a strobe transition.
- R10: One clock after `rd_beat_vld` falls, `dq_oe`, `dqs_oe`, `dqs_out` and `dq_out` return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_arm | input | 1 | Write window open |
| bl_sel | input | 2 | Burst length code |
| dqs_in | input | 2 | Per-lane write strobes |
| dq_in | input | 16 | Write data pins |
| dm_in | input | 2 | Per-lane write masks |
| burst_done | output | 1 | Burst complete pulse |
| burst_dq | output | 128 | Captured burst words, beat k at k*16 |
| burst_we | output | 16 | Byte enables, beat k lane l at k*2+l |
| rd_beat_vld | input | 1 | Read beat present |
| rd_word | input | 16 | Read word to drive |
| dq_out | output | 16 | Read data to the pins |
| dq_oe | output | 1 | Data output enable |
| dqs_out | output | 2 | Read strobes |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
On the write side, the pins pass through one sampling register and one capture register. The done pulse and the registered burst are therefore due two clocks after the edge that samples the later lane's final strobe transition. The bench drives that transition on a falling clock edge and then waits a fixed number of rising edges before checking. It expects done low after two rising edges and high after a third, and low again one clock later. On the read side, each word and strobe level is due one clock after it is offered. The bench checks the previous beat on each falling edge before it drives the next one. All checks sample on the falling clock edge, away from the edge that moves the outputs.

// File: rtl/dqs_cap_pkg.sv
package dqs_cap_pkg;

  // Beats per burst for a length code: 0 -> 2, 1 -> 4, otherwise 8.
  function automatic int unsigned burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction

  // Length limited to the storage the instance has.
  function automatic int unsigned beats_capped(input logic [1:0] code,
                                               input int unsigned limit);
    int unsigned n;
    n = burst_beats(code);
    return (n > limit) ? limit : n;
  endfunction

  // A high mask bit suppresses the byte: the enable is its inverse.
  function automatic logic byte_enable(input logic mask_bit);
    return ~mask_bit;
  endfunction

endpackage

// File: rtl/dqs_edge_det.sv
// Samples one lane's strobe, byte and mask into the clock domain and
// flags strobe transitions by comparing successive samples.
module dqs_edge_det #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic [LANE_W-1:0] byte_in,
  input  logic              mask_in,
  output logic              rise,
  output logic              fall,
  output logic [LANE_W-1:0] byte_q,
  output logic              mask_q
);
  logic s_strb, p_strb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_strb <= 1'b0;
      p_strb <= 1'b0;
      byte_q <= '0;
      mask_q <= 1'b0;
    end else begin
      s_strb <= strb;
      p_strb <= s_strb;
      byte_q <= byte_in;
      mask_q <= mask_in;
    end
  end

  assign rise = s_strb & ~p_strb;
  assign fall = ~s_strb & p_strb;
endmodule

// File: rtl/dqs_cap_lane.sv
// One byte lane: detects strobe transitions, waits for the first rising
// one, then stores one byte and mask bit per transition until the burst
// length is reached.
module dqs_cap_lane #(
  parameter int LANE_W    = 8,
  parameter int BEATS_MAX = 8,
  localparam int CW       = (BEATS_MAX > 1) ? $clog2(BEATS_MAX) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm,
  input  logic                        clear,
  input  logic [CW:0]                 len,
  input  logic                        strb,
  input  logic [LANE_W-1:0]           byte_in,
  input  logic                        mask_in,
  output logic                        cap,
  output logic                        fin,
  output logic [CW-1:0]               cnt,
  output logic [BEATS_MAX*LANE_W-1:0] slot_data,
  output logic [BEATS_MAX-1:0]        slot_mask
);
  logic              rise, fall, mask_q, started, last_beat;
  logic [LANE_W-1:0] byte_q;
  logic [BEATS_MAX-1:0][LANE_W-1:0] slots;

  dqs_edge_det #(.LANE_W(LANE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .strb(strb), .byte_in(byte_in),
    .mask_in(mask_in), .rise(rise), .fall(fall),
    .byte_q(byte_q), .mask_q(mask_q)
  );

  // Before the first rising edge only a rise may open the burst.
  assign cap       = arm & ~fin & ~clear & (started ? (rise | fall) : rise);
  assign last_beat = ({1'b0, cnt} == (len - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      fin       <= 1'b0;
      cnt       <= '0;
      slots     <= '0;
      slot_mask <= '0;
    end else if (clear || !arm) begin
      started <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
    end else if (cap) begin
      slots[cnt]     <= byte_q;
      slot_mask[cnt] <= mask_q;
      started        <= 1'b1;
      if (last_beat) begin
        fin <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign slot_data = slots;
endmodule

// File: rtl/dqs_rd_drive.sv
// Read side: registers each outgoing word and toggles the strobes in the
// same clock, so every data change meets a strobe transition.
module dqs_rd_drive #(
  parameter int NLANE  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = NLANE * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_vld,
  input  logic [DW-1:0]    word,
  output logic [DW-1:0]    dq_out,
  output logic             oe,
  output logic [NLANE-1:0] dqs_out
);
  logic lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      oe     <= 1'b0;
      lvl    <= 1'b0;
    end else if (beat_vld) begin
      dq_out <= word;
      oe     <= 1'b1;
      lvl    <= ~lvl;
    end else begin
      dq_out <= '0;
      oe     <= 1'b0;
      lvl    <= 1'b0;
    end
  end

  assign dqs_out = {NLANE{lvl}};
endmodule

// File: rtl/dqs_capture_unit.sv
module dqs_capture_unit #(
  parameter int NLANE     = 2,
  parameter int LANE_W    = 8,
  parameter int BEATS_MAX = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_arm,
  input  logic [1:0]                        bl_sel,
  input  logic [NLANE-1:0]                  dqs_in,
  input  logic [NLANE*LANE_W-1:0]           dq_in,
  input  logic [NLANE-1:0]                  dm_in,
  output logic                              burst_done,
  output logic [BEATS_MAX*NLANE*LANE_W-1:0] burst_dq,
  output logic [BEATS_MAX*NLANE-1:0]        burst_we,
  input  logic                              rd_beat_vld,
  input  logic [NLANE*LANE_W-1:0]           rd_word,
  output logic [NLANE*LANE_W-1:0]           dq_out,
  output logic                              dq_oe,
  output logic [NLANE-1:0]                  dqs_out,
  output logic                              dqs_oe
);
  import dqs_cap_pkg::*;

  localparam int DW = NLANE * LANE_W;
  localparam int CW = (BEATS_MAX > 1) ? $clog2(BEATS_MAX) : 1;

  // Named internal events, observed by the bound checker.
  logic [NLANE-1:0]    cap_lane;
  logic [NLANE-1:0]    fin_lane;
  logic [NLANE*CW-1:0] lane_cnt;
  logic [CW:0]         cur_len;
  logic                all_fin;
  logic                done_q;

  logic [BEATS_MAX*LANE_W-1:0] lane_data [NLANE];
  logic [BEATS_MAX-1:0]        lane_mask [NLANE];
  logic [BEATS_MAX*DW-1:0]     asm_dq;
  logic [BEATS_MAX*NLANE-1:0]  asm_we;

  assign cur_len = (CW+1)'(beats_capped(bl_sel, BEATS_MAX));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    dqs_cap_lane #(.LANE_W(LANE_W), .BEATS_MAX(BEATS_MAX)) u_lane (
      .clk(clk), .rst_n(rst_n), .arm(wr_arm), .clear(done_q),
      .len(cur_len), .strb(dqs_in[l]),
      .byte_in(dq_in[l*LANE_W +: LANE_W]), .mask_in(dm_in[l]),
      .cap(cap_lane[l]), .fin(fin_lane[l]),
      .cnt(lane_cnt[l*CW +: CW]),
      .slot_data(lane_data[l]), .slot_mask(lane_mask[l])
    );
  end

  // Interleave lanes into beat words and beat enable pairs.
  always_comb begin
    for (int k = 0; k < BEATS_MAX; k++) begin
      for (int l = 0; l < NLANE; l++) begin
        asm_dq[k*DW + l*LANE_W +: LANE_W] = lane_data[l][k*LANE_W +: LANE_W];
        asm_we[k*NLANE + l]               = byte_enable(lane_mask[l][k]);
      end
    end
  end

  assign all_fin = &fin_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      burst_dq <= '0;
      burst_we <= '0;
    end else if (all_fin && !done_q) begin
      done_q   <= 1'b1;
      burst_dq <= asm_dq;
      burst_we <= asm_we;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign burst_done = done_q;

  dqs_rd_drive #(.NLANE(NLANE), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .beat_vld(rd_beat_vld), .word(rd_word),
    .dq_out(dq_out), .oe(dq_oe), .dqs_out(dqs_out)
  );

  assign dqs_oe = dq_oe;
endmodule

// File: rtl/dqs_capture_chk.sv
module dqs_capture_chk #(
  parameter int NLANE     = 2,
  parameter int BEATS_MAX = 8,
  localparam int CW       = (BEATS_MAX > 1) ? $clog2(BEATS_MAX) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_arm,
  input logic [NLANE-1:0]    dqs_in,
  input logic [NLANE-1:0]    cap_lane,
  input logic [NLANE-1:0]    fin_lane,
  input logic [NLANE*CW-1:0] lane_cnt,
  input logic [CW:0]         cur_len,
  input logic                burst_done,
  input logic                dq_oe,
  input logic                dqs_oe,
  input logic [NLANE-1:0]    dqs_out
);
  for (genvar l = 0; l < NLANE; l++) begin : g_l
    // R1, R2: a lane captures only after its own strobe changed level
    a_r1_cap_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      cap_lane[l] |-> ($past(dqs_in[l]) != $past(dqs_in[l], 2)));
    // R5: nothing is captured outside the write window
    a_r5_cap_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      cap_lane[l] |-> wr_arm);
    // R4: the beat index stays below the burst length
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, lane_cnt[l*CW +: CW]} < cur_len);
    // R7: a finished lane takes no more beats
    a_r7_fin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fin_lane[l] |-> !cap_lane[l]);
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  a_r6_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(&fin_lane));
  a_r9_edge_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (dqs_out[0] != $past(dqs_out[0])));
  a_r9_first_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> dqs_out[0]);
  a_r9_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_out == {NLANE{dqs_out[0]}});
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe |-> (dqs_out == '0));
endmodule

bind dqs_capture_unit dqs_capture_chk #(.NLANE(NLANE), .BEATS_MAX(BEATS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .dqs_in(dqs_in),
  .cap_lane(cap_lane), .fin_lane(fin_lane), .lane_cnt(lane_cnt),
  .cur_len(cur_len), .burst_done(burst_done), .dq_oe(dq_oe),
  .dqs_oe(dqs_oe), .dqs_out(dqs_out)
);

// File: tb/sim_dqs_capture_unit.sv
module sim_dqs_capture_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_arm = 1'b0;
  logic [1:0]   bl_sel = 2'd0;
  logic [1:0]   dqs_in = 2'b00;
  logic [15:0]  dq_in = 16'h0;
  logic [1:0]   dm_in = 2'b00;
  logic         burst_done;
  logic [127:0] burst_dq;
  logic [15:0]  burst_we;
  logic         rd_beat_vld = 1'b0;
  logic [15:0]  rd_word = 16'h0;
  logic [15:0]  dq_out;
  logic         dq_oe;
  logic [1:0]   dqs_out;
  logic         dqs_oe;

  int vectors = 0;
  int fails = 0;
  bit ended = 0;

  dqs_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .bl_sel(bl_sel),
    .dqs_in(dqs_in), .dq_in(dq_in), .dm_in(dm_in),
    .burst_done(burst_done), .burst_dq(burst_dq), .burst_we(burst_we),
    .rd_beat_vld(rd_beat_vld), .rd_word(rd_word), .dq_out(dq_out),
    .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe)
  );

  always #10ns clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int blen(input int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  function automatic logic [7:0] ebyte(input int code, input int skew,
                                       input int pat, input int l, input int k);
    return 8'((k*29 + l*83 + code*7 + skew*13 + pat*3 + 17) % 256);
  endfunction

  function automatic bit emask(input int pat, input int l, input int k);
    case (pat)
      0:       return 1'b0;
      1:       return 1'((k + l) % 2);
      2:       return (k % 3) == l;
      default: return 1'b1;
    endcase
  endfunction

  // One write burst. Lane 1 lags lane 0 by skew clocks; 4 clocks per beat,
  // data set at phase 0 and the strobe moved at phase 2 (mid bit).
  task automatic run_burst(input int code, input int skew, input int pat,
                           input bit junk, input bit pre_high);
    int  len, last;
    bit  early;
    len   = blen(code);
    last  = skew + 4*(len-1) + 2;
    early = 0;
    if (pre_high) begin
      // Unarmed toggles with junk data (R5), ending high.
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        dqs_in = (i % 2 == 0) ? 2'b11 : 2'b00;
        dq_in  = 16'hDEAD;
        if (i == 5) dqs_in = 2'b11;
      end
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    wr_arm = 1'b1;
    bl_sel = 2'(code);
    if (pre_high) begin
      repeat (2) @(negedge clk);
      dqs_in = 2'b00;   // preamble: falling edge before the first rise
      dq_in  = 16'hBEEF;
      repeat (2) @(negedge clk);
    end
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      if (burst_done) early = 1;
      for (int l = 0; l < 2; l++) begin
        int loc, b, ph;
        loc = c - ((l == 1) ? skew : 0);
        if (loc >= 0) begin
          b  = loc / 4;
          ph = loc % 4;
          if (b < len) begin
            if (ph == 0) begin
              dq_in[l*8 +: 8] = ebyte(code, skew, pat, l, b);
              dm_in[l]        = emask(pat, l, b);
            end else if (ph == 2) begin
              dqs_in[l] = (b % 2 == 0);
            end
          end else if (junk && l == 0 && b == len) begin
            if (ph == 0) begin
              dq_in[7:0] = 8'hA5;
              dm_in[0]   = 1'b1;
            end else if (ph == 2) begin
              dqs_in[0] = 1'b1;   // extra edge after lane 0 finished (R7)
            end
          end
        end
      end
    end
    chk(!early, "R6 no early done", 32'(early), 32'd0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(burst_done == 1'b0, "R6 done not before two clocks", 32'(burst_done), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(burst_done == 1'b1, "R6 done after two clocks", 32'(burst_done), 32'd1);
    for (int k = 0; k < len; k++) begin
      logic [15:0] ew;
      logic [1:0]  ee;
      ew = {ebyte(code, skew, pat, 1, k), ebyte(code, skew, pat, 0, k)};
      ee = {~emask(pat, 1, k), ~emask(pat, 0, k)};
      chk(burst_dq[k*16 +: 16] == ew, "R1 R2 R4 R5 R7 beat data",
          32'(burst_dq[k*16 +: 16]), 32'(ew));
      chk(burst_we[k*2 +: 2] == ee, "R3 beat enables",
          32'(burst_we[k*2 +: 2]), 32'(ee));
    end
    @(negedge clk);
    chk(burst_done == 1'b0, "R6 done is one clock", 32'(burst_done), 32'd0);
    wr_arm = 1'b0;
    dqs_in = 2'b00;
    dm_in  = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_read(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j > 0) begin
        chk(dq_out == 16'(n*1000 + j - 1), "R9 read word", 32'(dq_out), 32'(n*1000 + j - 1));
        chk(dq_oe && dqs_oe, "R9 enables", {30'd0, dq_oe, dqs_oe}, 32'd3);
        chk(dqs_out == (((j-1) % 2 == 0) ? 2'b11 : 2'b00), "R9 strobe level",
            32'(dqs_out), ((j-1) % 2 == 0) ? 32'd3 : 32'd0);
      end
      rd_beat_vld = 1'b1;
      rd_word     = 16'(n*1000 + j);
    end
    @(negedge clk);
    chk(dq_out == 16'(n*1000 + n - 1), "R9 last read word", 32'(dq_out), 32'(n*1000 + n - 1));
    chk(dqs_out == (((n-1) % 2 == 0) ? 2'b11 : 2'b00), "R9 last strobe level",
        32'(dqs_out), ((n-1) % 2 == 0) ? 32'd3 : 32'd0);
    rd_beat_vld = 1'b0;
    rd_word     = 16'hFFFF;
    @(negedge clk);
    chk(!dq_oe && !dqs_oe && dqs_out == 2'b00 && dq_out == 16'h0, "R10 read idle",
        {dq_out, 12'd0, dq_oe, dqs_oe, dqs_out}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burst_done == 1'b0 && burst_dq == '0 && burst_we == '0, "R8 write outputs reset",
        {31'd0, burst_done}, 32'd0);
    chk(dq_out == '0 && !dq_oe && !dqs_oe && dqs_out == '0, "R8 read outputs reset",
        {dq_out, 12'd0, dq_oe, dqs_oe, dqs_out}, 32'd0);
    for (int code = 0; code < 4; code++)
      for (int si = 0; si < 3; si++)
        for (int pat = 0; pat < 4; pat++) begin
          int skew;
          skew = (si == 0) ? 0 : (si == 1) ? 1 : 5;
          run_burst(code, skew, pat, (skew == 5 && pat == 1), 1'b0);
        end
    run_burst(1, 2, 2, 1'b0, 1'b1);
    run_burst(3, 0, 1, 1'b0, 1'b1);
    for (int n = 1; n <= 5; n++) run_read(n);
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule